// File: doc/BRIEF.md
# Interrupt Daisy-Chain and Vector Unit

This unit runs the interrupt side of a two-port peripheral that sits on a prioritised daisy chain. Each port sends a one-cycle request pulse when it needs service. The unit holds the request as pending and pulls the active-low interrupt line when the chain lets it. When the processor acknowledges, the unit places the winning port's 8-bit vector on the data bus. It then marks that port as in service. That state stays set until the unit sees the two-byte return-from-interrupt opcode go past on the bus during opcode fetches.

The chain uses two signals. The enable input from upstream tells the unit that no higher-priority device is in service. The enable output tells downstream devices the same about this unit. Port 0 outranks port 1. A port in service blocks every port below it, inside the unit and further down the chain. A higher-priority port can still interrupt a lower one that is in service. There is no write pin: the unit builds its own write strobe from the bus control lines. The unit accepts two control words: a vector load and an interrupt enable/disable word. A newly armed enable waits for the next opcode-fetch cycle before it takes effect.

Top module: `irq_chain_unit`

## Requirements
- R1: A register write happens only in a cycle with `cs_n`=0, `iorq_n`=0, `rd_n`=1 and `m1_n`=1, and with `ctrl_sel`=1 for control words. A cycle with `rd_n` low, with `cs_n` high, or with `ctrl_sel` low changes nothing.
- R2: A control word with bit 0 = 0 loads bits 7:1 into the vector of the port picked by `port_sel` (0 = port 0). The vector driven during acknowledge is those bits with bit 0 = 0.
- R3: A control word whose low nibble is 0011 controls the enable of the selected port. With bit 7 = 1 it arms the enable, which takes effect only after a later cycle with `m1_n` low. With bit 7 = 0 it disables the port at once. A request pulse that arrives while the port is not enabled is dropped.
- R4: A request pulse on an enabled port makes it pending. `int_n` is low while any enabled pending port has `ien_in` high and has neither itself nor a higher-priority port in service.
- R5: In a cycle with `m1_n` and `iorq_n` both low, the highest-priority presenting port wins. Its vector is driven on `vec_out` with `vec_oe` high. When the acknowledge ends, that port stops pending and enters service.
- R6: `ien_out` is high only when `ien_in` is high and no port is in service. It is also low while `m1_n` is low and any enabled port is pending.
- R7: While port 0 is in service, port 1 cannot present. While port 1 is in service, port 0 can present and be acknowledged.
- R8: Two opcode fetches (`m1_n`=0, `rd_n`=0, `iorq_n`=1) in a row carrying ED and then 4D release the highest-priority port in service. The release happens only if `ien_in` is high. Any other fetch between the two bytes cancels the match.
- R9: After reset nothing is pending, enabled or in service. `int_n` is high, `vec_oe` is low and `ien_out` follows `ien_in`.
- R10: In a chain of two units, the downstream unit neither presents nor answers an acknowledge while the upstream unit has a port in service or has a request waiting during M1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| m1_n | input | 1 | Opcode-fetch / acknowledge marker, active low |
| ctrl_sel | input | 1 | 1 = control word, 0 = data transfer |
| port_sel | input | SEL_W | Port addressed by a write (0 = highest priority) |
| bus_in | input | 8 | Data bus as seen by the unit |
| req_in | input | NPORTS | One-cycle service request per port |
| ien_in | input | 1 | Chain enable from the upstream device |
| ien_out | output | 1 | Chain enable to the downstream device |
| int_n | output | 1 | Interrupt request, active low |
| vec_out | output | 8 | Vector driven during acknowledge |
| vec_oe | output | 1 | Vector drive enable |

## Verification
Any wrong in-service or pending bit shows up at the pins within one cycle. `ien_out` responds to the in-service state combinationally. `int_n` follows pending state one clock after the pulse. A stale in-service bit keeps the downstream unit blocked until the next return opcode. A lost one lets the lower port present early. A wrong grant shows up in the same acknowledge cycle as a wrong vector or two active drive enables. A broken opcode matcher appears two cycles after the 4D fetch, when `ien_out` fails to rise or a blocked port fails to present.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int VEC_W = 8;

    localparam logic [7:0] OP_PREFIX   = 8'hED;
    localparam logic [7:0] OP_RET_TAIL = 8'h4D;
    localparam logic [3:0] IEN_WORD    = 4'b0011;

    typedef struct packed {
        logic             pend;
        logic             ie;
        logic             arm;
        logic             isr;
        logic [VEC_W-1:0] vec;
    } slot_state_t;

    typedef struct packed {
        logic       ack;
        logic       fetch;
        logic [7:0] op;
        logic       saw_prefix;
    } bus_state_t;

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       iorq_n,
    input  logic       rd_n,
    input  logic       m1_n,
    input  logic       ctrl_sel,
    input  logic [7:0] bus_in,
    output logic       vec_wr,
    output logic       ien_wr,
    output logic       ien_val,
    output logic       m1_low,
    output logic       ack_active,
    output logic       ack_start,
    output logic       ack_end,
    output logic       reti_hit
);

    bus_state_t st_d, st_q;
    logic wr_strobe;
    logic ctl_wr;
    logic fetch_now;

    always_comb begin
        // internal write: selected, I/O cycle, not a read, not an M1 cycle
        wr_strobe  = !cs_n && !iorq_n && rd_n && m1_n;
        ctl_wr     = wr_strobe && ctrl_sel;
        vec_wr     = ctl_wr && !bus_in[0];
        ien_wr     = ctl_wr && (bus_in[3:0] == IEN_WORD);
        ien_val    = bus_in[7];
        m1_low     = !m1_n;
        ack_active = !m1_n && !iorq_n;
        fetch_now  = !m1_n && !rd_n && iorq_n;

        ack_start  = ack_active && !st_q.ack;
        ack_end    = st_q.ack && !ack_active;
        reti_hit   = st_q.fetch && !fetch_now && st_q.saw_prefix
                     && (st_q.op == OP_RET_TAIL);

        st_d       = st_q;
        st_d.ack   = ack_active;
        st_d.fetch = fetch_now;
        if (fetch_now) begin
            st_d.op = bus_in;
        end
        if (st_q.fetch && !fetch_now) begin
            st_d.saw_prefix = (st_q.op == OP_PREFIX);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/irq_port_slot.sv
module irq_port_slot
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vec_load,
    input  logic [VEC_W-2:0] vec_hi,
    input  logic             ien_load,
    input  logic             ien_val,
    input  logic             m1_low,
    input  logic             req,
    input  logic             commit,
    input  logic             release_svc,
    output logic [VEC_W-1:0] vec,
    output logic             pend,
    output logic             ie,
    output logic             isr
);

    slot_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (vec_load) begin
            st_d.vec = {vec_hi, 1'b0};
        end
        if (ien_load) begin
            if (ien_val) begin
                st_d.arm = 1'b1;
            end else begin
                st_d.arm = 1'b0;
                st_d.ie  = 1'b0;
            end
        end else if (st_q.arm && m1_low) begin
            st_d.ie  = 1'b1;
            st_d.arm = 1'b0;
        end
        st_d.pend = (st_q.pend && !commit) || (req && st_q.ie);
        if (commit) begin
            st_d.isr = 1'b1;
        end else if (release_svc) begin
            st_d.isr = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vec  = st_q.vec;
    assign pend = st_q.pend;
    assign ie   = st_q.ie;
    assign isr  = st_q.isr;

endmodule

// File: rtl/irq_chain_arbiter.sv
module irq_chain_arbiter #(
    parameter int NPORTS = 2
) (
    input  logic              ien_in,
    input  logic              m1_low,
    input  logic [NPORTS-1:0] pend,
    input  logic [NPORTS-1:0] ie,
    input  logic [NPORTS-1:0] isr,
    output logic [NPORTS-1:0] present,
    output logic [NPORTS-1:0] winner,
    output logic              ien_out
);

    always_comb begin
        logic chain;
        logic found;
        logic waiting;
        chain   = ien_in;
        found   = 1'b0;
        waiting = 1'b0;
        for (int i = 0; i < NPORTS; i++) begin
            present[i] = pend[i] && ie[i] && !isr[i] && chain;
            winner[i]  = present[i] && !found;
            found      = found || present[i];
            waiting    = waiting || (pend[i] && ie[i]);
            chain      = chain && !isr[i];
        end
        ien_out = chain && !(m1_low && waiting);
    end

endmodule

// File: rtl/irq_chain_unit.sv
module irq_chain_unit
    import irq_pkg::*;
#(
    parameter int  NPORTS = 2,
    localparam int SEL_W  = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              iorq_n,
    input  logic              rd_n,
    input  logic              m1_n,
    input  logic              ctrl_sel,
    input  logic [SEL_W-1:0]  port_sel,
    input  logic [7:0]        bus_in,
    input  logic [NPORTS-1:0] req_in,
    input  logic              ien_in,
    output logic              ien_out,
    output logic              int_n,
    output logic [7:0]        vec_out,
    output logic              vec_oe
);

    logic vec_wr, ien_wr, ien_val, m1_low;
    logic ack_active, ack_start, ack_end, reti_hit;

    logic [NPORTS-1:0] pend_vec, ie_vec, isr_vec;
    logic [NPORTS-1:0] present, winner, sel_vec;
    logic [NPORTS-1:0] commit, release_svc;
    logic [NPORTS-1:0] grant_d, grant_q;
    logic [VEC_W-1:0]  vec_arr [NPORTS];

    irq_bus_decode u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .iorq_n     (iorq_n),
        .rd_n       (rd_n),
        .m1_n       (m1_n),
        .ctrl_sel   (ctrl_sel),
        .bus_in     (bus_in),
        .vec_wr     (vec_wr),
        .ien_wr     (ien_wr),
        .ien_val    (ien_val),
        .m1_low     (m1_low),
        .ack_active (ack_active),
        .ack_start  (ack_start),
        .ack_end    (ack_end),
        .reti_hit   (reti_hit)
    );

    for (genvar g = 0; g < NPORTS; g++) begin : g_slot
        irq_port_slot u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .vec_load    (vec_wr && (port_sel == SEL_W'(g))),
            .vec_hi      (bus_in[VEC_W-1:1]),
            .ien_load    (ien_wr && (port_sel == SEL_W'(g))),
            .ien_val     (ien_val),
            .m1_low      (m1_low),
            .req         (req_in[g]),
            .commit      (commit[g]),
            .release_svc (release_svc[g]),
            .vec         (vec_arr[g]),
            .pend        (pend_vec[g]),
            .ie          (ie_vec[g]),
            .isr         (isr_vec[g])
        );
    end

    irq_chain_arbiter #(.NPORTS(NPORTS)) u_arb (
        .ien_in  (ien_in),
        .m1_low  (m1_low),
        .pend    (pend_vec),
        .ie      (ie_vec),
        .isr     (isr_vec),
        .present (present),
        .winner  (winner),
        .ien_out (ien_out)
    );

    always_comb begin
        logic blocked;
        blocked = 1'b0;
        for (int i = 0; i < NPORTS; i++) begin
            release_svc[i] = reti_hit && ien_in && isr_vec[i] && !blocked;
            blocked        = blocked || isr_vec[i];
            commit[i]      = ack_end && grant_q[i];
        end

        if (ack_start) begin
            grant_d = winner;
        end else if (ack_end) begin
            grant_d = '0;
        end else begin
            grant_d = grant_q;
        end

        sel_vec = ack_start ? winner : grant_q;
        vec_out = '0;
        for (int i = 0; i < NPORTS; i++) begin
            if (ack_active && sel_vec[i]) begin
                vec_out = vec_out | vec_arr[i];
            end
        end
        vec_oe = ack_active && (|sel_vec);
        int_n  = !(|present);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= '0;
        end else begin
            grant_q <= grant_d;
        end
    end

endmodule

// File: rtl/irq_chain_unit_chk.sv
module irq_chain_unit_chk #(
    parameter int NPORTS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ien_in,
    input logic              ien_out,
    input logic              int_n,
    input logic              vec_oe,
    input logic [7:0]        vec_out,
    input logic [NPORTS-1:0] grant_q,
    input logic [NPORTS-1:0] isr_vec
);

    // R2: a driven vector never has bit 0 set
    p_vec_lsb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |-> !vec_out[0]) else $error("vector bit 0 set");

    // R4: no request is presented without the chain enable
    p_int_needs_iei_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !int_n |-> ien_in) else $error("int without chain enable");

    // R5: at most one port is granted
    p_grant_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_q)) else $error("multiple grants");

    // R6: a port in service blocks the chain
    p_ieo_in_service_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|isr_vec) |-> !ien_out) else $error("chain open during service");

    // R6: chain output never rises without chain input
    p_ieo_needs_iei_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ien_in |-> !ien_out) else $error("chain out without chain in");

    // R8: a service bit only clears while the chain input was high
    p_release_needs_iei_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(isr_vec) & ~isr_vec)) |-> $past(ien_in))
        else $error("release with chain input low");

endmodule

bind irq_chain_unit irq_chain_unit_chk #(.NPORTS(NPORTS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ien_in  (ien_in),
    .ien_out (ien_out),
    .int_n   (int_n),
    .vec_oe  (vec_oe),
    .vec_out (vec_out),
    .grant_q (grant_q),
    .isr_vec (isr_vec)
);

// File: tb/irq_chain_unit_test.sv
module irq_chain_unit_test;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_up_n = 1'b1, cs_dn_n = 1'b1;
    logic       iorq_n = 1'b1, rd_n = 1'b1, m1_n = 1'b1;
    logic       ctrl_sel = 1'b0;
    logic       port_sel = 1'b0;
    logic [7:0] bus = 8'h00;
    logic [1:0] req_up = 2'b00, req_dn = 2'b00;
    logic       ien_top = 1'b1;

    logic       ieo_up, ieo_dn, int_up_n, int_dn_n, oe_up, oe_dn;
    logic [7:0] vec_up, vec_dn;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    irq_chain_unit uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_up_n), .iorq_n(iorq_n), .rd_n(rd_n),
        .m1_n(m1_n), .ctrl_sel(ctrl_sel), .port_sel(port_sel), .bus_in(bus),
        .req_in(req_up), .ien_in(ien_top), .ien_out(ieo_up), .int_n(int_up_n),
        .vec_out(vec_up), .vec_oe(oe_up)
    );

    irq_chain_unit uut_dn (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_dn_n), .iorq_n(iorq_n), .rd_n(rd_n),
        .m1_n(m1_n), .ctrl_sel(ctrl_sel), .port_sel(port_sel), .bus_in(bus),
        .req_in(req_dn), .ien_in(ieo_up), .ien_out(ieo_dn), .int_n(int_dn_n),
        .vec_out(vec_dn), .vec_oe(oe_dn)
    );

    // step: [27:24] requirement, [23:20] op, [19] device, [18] port,
    //       [15:8] data, [7:0] expected
    // ops: 1 control write, 2 request pulse, 3 acknowledge, 4 fetch,
    //      5 check int_n, 6 check upstream ien_out
    localparam int NSTEP = 38;
    localparam logic [27:0] STEPS [NSTEP] = '{
        {4'd2, 4'd1, 1'b0, 1'b0, 2'b0, 8'h20, 8'h00},  // R2 vectors
        {4'd2, 4'd1, 1'b0, 1'b1, 2'b0, 8'h40, 8'h00},
        {4'd2, 4'd1, 1'b1, 1'b0, 2'b0, 8'h60, 8'h00},
        {4'd2, 4'd1, 1'b1, 1'b1, 2'b0, 8'h80, 8'h00},
        {4'd3, 4'd1, 1'b0, 1'b0, 2'b0, 8'h83, 8'h00},  // R3 enables
        {4'd3, 4'd1, 1'b0, 1'b1, 2'b0, 8'h83, 8'h00},
        {4'd3, 4'd1, 1'b1, 1'b0, 2'b0, 8'h83, 8'h00},
        {4'd3, 4'd1, 1'b1, 1'b1, 2'b0, 8'h83, 8'h00},
        {4'd3, 4'd4, 1'b0, 1'b0, 2'b0, 8'h00, 8'h00},
        {4'd4, 4'd2, 1'b0, 1'b1, 2'b0, 8'h00, 8'h00},  // R4
        {4'd4, 4'd2, 1'b0, 1'b0, 2'b0, 8'h00, 8'h00},
        {4'd4, 4'd5, 1'b0, 1'b0, 2'b0, 8'h00, 8'h00},
        {4'd5, 4'd3, 1'b0, 1'b0, 2'b0, 8'h00, 8'h20},  // R5 port 0 wins
        {4'd6, 4'd6, 1'b0, 1'b0, 2'b0, 8'h00, 8'h00},  // R6
        {4'd10, 4'd2, 1'b1, 1'b0, 2'b0, 8'h00, 8'h00}, // R10
        {4'd10, 4'd5, 1'b1, 1'b0, 2'b0, 8'h00, 8'h01},
        {4'd7, 4'd5, 1'b0, 1'b0, 2'b0, 8'h00, 8'h01},  // R7 port 1 blocked
        {4'd8, 4'd4, 1'b0, 1'b0, 2'b0, 8'hED, 8'h00},  // R8
        {4'd8, 4'd4, 1'b0, 1'b0, 2'b0, 8'h4D, 8'h00},
        {4'd4, 4'd5, 1'b0, 1'b0, 2'b0, 8'h00, 8'h00},
        {4'd5, 4'd3, 1'b0, 1'b0, 2'b0, 8'h00, 8'h40},
        {4'd7, 4'd2, 1'b0, 1'b0, 2'b0, 8'h00, 8'h00},  // R7 nesting
        {4'd7, 4'd5, 1'b0, 1'b0, 2'b0, 8'h00, 8'h00},
        {4'd7, 4'd3, 1'b0, 1'b0, 2'b0, 8'h00, 8'h20},
        {4'd8, 4'd4, 1'b0, 1'b0, 2'b0, 8'hED, 8'h00},
        {4'd8, 4'd4, 1'b0, 1'b0, 2'b0, 8'h4D, 8'h00},
        {4'd8, 4'd6, 1'b0, 1'b0, 2'b0, 8'h00, 8'h00},
        {4'd8, 4'd4, 1'b0, 1'b0, 2'b0, 8'hED, 8'h00},
        {4'd8, 4'd4, 1'b0, 1'b0, 2'b0, 8'h4D, 8'h00},
        {4'd8, 4'd6, 1'b0, 1'b0, 2'b0, 8'h00, 8'h01},
        {4'd10, 4'd5, 1'b1, 1'b0, 2'b0, 8'h00, 8'h00},
        {4'd2, 4'd3, 1'b1, 1'b0, 2'b0, 8'h00, 8'h60},
        {4'd7, 4'd2, 1'b1, 1'b1, 2'b0, 8'h00, 8'h00},
        {4'd7, 4'd5, 1'b1, 1'b0, 2'b0, 8'h00, 8'h01},
        {4'd8, 4'd4, 1'b0, 1'b0, 2'b0, 8'hED, 8'h00},
        {4'd8, 4'd4, 1'b0, 1'b0, 2'b0, 8'h4D, 8'h00},
        {4'd8, 4'd5, 1'b1, 1'b0, 2'b0, 8'h00, 8'h00},
        {4'd2, 4'd3, 1'b1, 1'b0, 2'b0, 8'h00, 8'h80}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic idle();
        cs_up_n = 1'b1; cs_dn_n = 1'b1; iorq_n = 1'b1; rd_n = 1'b1; m1_n = 1'b1;
        ctrl_sel = 1'b0; port_sel = 1'b0; bus = 8'h00; req_up = 2'b00; req_dn = 2'b00;
    endtask

    task automatic bus_cycle(input bit cup, input bit cdn, input bit iq, input bit rd,
                             input bit m1, input bit ctl, input bit ps, input logic [7:0] d);
        cs_up_n = cup; cs_dn_n = cdn; iorq_n = iq; rd_n = rd; m1_n = m1;
        ctrl_sel = ctl; port_sel = ps; bus = d;
        @(negedge clk);
        idle();
    endtask

    task automatic wr_ctrl(input bit dev, input bit port, input logic [7:0] d);
        bus_cycle(dev, !dev, 1'b0, 1'b1, 1'b1, 1'b1, port, d);
    endtask

    task automatic fetch(input logic [7:0] d);
        bus_cycle(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, d);
        @(negedge clk);
    endtask

    task automatic pulse_req(input bit dev, input bit port);
        if (dev) req_dn[port] = 1'b1; else req_up[port] = 1'b1;
        @(negedge clk);
        req_up = 2'b00; req_dn = 2'b00;
    endtask

    task automatic look_int(input bit dev, input bit exp, input string tag);
        #5;
        chk(tag, {7'b0, dev ? int_dn_n : int_up_n}, {7'b0, exp});
        @(negedge clk);
    endtask

    task automatic look_ieo(input bit exp, input string tag);
        #5;
        chk(tag, {7'b0, ieo_up}, {7'b0, exp});
        @(negedge clk);
    endtask

    task automatic do_ack(input bit dev, input logic [7:0] exp, input string tag);
        m1_n = 1'b0; iorq_n = 1'b0;
        #5;
        chk(tag, dev ? vec_dn : vec_up, exp);
        chk(tag, {6'b0, oe_dn, oe_up}, dev ? 8'h02 : 8'h01);
        @(negedge clk);
        idle();
        @(negedge clk);
    endtask

    task automatic do_reset();
        idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_step(input logic [27:0] s);
        string tag;
        tag = $sformatf("R%0d table", s[27:24]);
        case (s[23:20])
            4'd1: wr_ctrl(s[19], s[18], s[15:8]);
            4'd2: pulse_req(s[19], s[18]);
            4'd3: do_ack(s[19], s[7:0], tag);
            4'd4: fetch(s[15:8]);
            4'd5: look_int(s[19], s[0], tag);
            4'd6: look_ieo(s[0], tag);
            default: @(negedge clk);
        endcase
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R9: reset state at the ports
        look_int(1'b0, 1'b1, "R9 int_n upstream");
        look_int(1'b1, 1'b1, "R9 int_n downstream");
        look_ieo(1'b1, "R9 ien_out");
        m1_n = 1'b0; iorq_n = 1'b0;
        #5;
        chk("R9 no vector drive", {6'b0, oe_dn, oe_up}, 8'h00);
        @(negedge clk);
        idle();
        @(negedge clk);

        for (int k = 0; k < NSTEP; k++) begin
            run_step(STEPS[k]);
        end

        do_reset();

        // R3: enable only after an M1 cycle; disable at once
        wr_ctrl(1'b0, 1'b0, 8'h2A);
        wr_ctrl(1'b0, 1'b0, 8'h83);
        pulse_req(1'b0, 1'b0);
        look_int(1'b0, 1'b1, "R3 request before M1 dropped");
        fetch(8'h00);
        look_int(1'b0, 1'b1, "R3 nothing pending after M1");
        pulse_req(1'b0, 1'b0);
        look_int(1'b0, 1'b0, "R3 request after M1 taken");
        wr_ctrl(1'b0, 1'b0, 8'h03);
        look_int(1'b0, 1'b1, "R3 disable immediate");
        wr_ctrl(1'b0, 1'b0, 8'h83);
        fetch(8'h00);
        look_int(1'b0, 1'b0, "R3 pending kept over disable");

        // R1: malformed writes have no effect
        bus_cycle(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h03);
        look_int(1'b0, 1'b0, "R1 write with rd_n low ignored");
        bus_cycle(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h03);
        look_int(1'b0, 1'b0, "R1 write with cs_n high ignored");
        bus_cycle(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h03);
        look_int(1'b0, 1'b0, "R1 data write ignored");
        bus_cycle(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h10);
        do_ack(1'b0, 8'h2A, "R1 vector kept after deselected write");

        // R6: in service closes the chain
        look_ieo(1'b0, "R6 in service");

        // R8: return opcode ignored with chain input low, and when split
        ien_top = 1'b0;
        fetch(8'hED);
        fetch(8'h4D);
        ien_top = 1'b1;
        look_ieo(1'b0, "R8 release ignored while ien_in low");
        fetch(8'hED);
        fetch(8'h00);
        fetch(8'h4D);
        look_ieo(1'b0, "R8 split opcode ignored");
        fetch(8'hED);
        fetch(8'h4D);
        look_ieo(1'b1, "R8 release");

        // R6: pending request holds the chain low only during M1
        pulse_req(1'b0, 1'b0);
        m1_n = 1'b0;
        #5;
        chk("R6 ien_out low in M1 with pending", {7'b0, ieo_up}, 8'h00);
        @(negedge clk);
        idle();
        look_ieo(1'b1, "R6 ien_out high outside M1");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule